// File: doc/BRIEF.md
# Register-File Slave on a Two-Wire Serial Bus

This block is a target device on a standard-mode (up to 100 kHz) two-wire serial bus holding seven 8-bit control registers for the rest of the chip. A bus master writes one or more bytes in one transaction. The first byte after the device address selects a register, and every later byte lands in the next register. The master reads either from where the last access left off, or from a chosen register by writing the register number and then issuing a repeated START.

The block samples both bus lines with the system clock. It synchronizes and deglitches them, and it drives the data line only by pulling it low. An internal register pointer advances after each byte written or sent, and it wraps from the last register back to the first. Two pins choose the low bits of the device address, so up to four of these blocks can share one bus. The register contents and their reset values are brought out as flat vectors. An active-low power-down input holds all registers at their reset values.

Top module: `i2cr_top`

## Requirements
- R1: The 7-bit device address is binary 00100 followed by addr_sel[1], addr_sel[0]. The eighth bit of the first byte selects the direction: 1 means read, 0 means write. On a match the slave acknowledges (pulls SDA low in the ninth clock). With any other address it never pulls SDA for the rest of that transaction.
- R2: In a write, the byte after the address loads the register pointer from its low five bits. Each later byte is stored at the pointer, and the pointer then advances. Every byte is acknowledged.
- R3: The pointer advances from 6 to 0. Any value above 6 also advances to 0. A burst that runs past register 6 therefore overwrites register 0 onward.
- R4: A read that follows the device address directly (current-address read) starts at the pointer left by the previous access. That is one past the last register written or sent.
- R5: A write of the pointer byte, followed by a repeated START with the read bit set, reads from the chosen register. Each byte sent advances the pointer.
- R6: While the master acknowledges, the slave sends the next register. When the master does not acknowledge, the slave releases SDA and sends nothing more until the next START.
- R7: After reset, registers 0 to 6 hold 80h, 20h, 00h, 10h, 10h, 10h, 10h. defaults_o always carries these values, with register k in bits 8k+7:8k.
- R8: While pwr_down_n is low, all registers are held at their R7 values and bus writes have no effect.
- R9: A START or STOP seen in the middle of a byte abandons that byte, and it is not stored. A repeated START begins a new address phase.
- R10: The slave drives SDA only as a low level, only in its acknowledge slots and in read data bits. The driven level changes only while SCL is low.
- R11: A write to a pointer above 6 changes no register. A read from such a pointer returns 00h.
- R12: Pulses on SCL or SDA shorter than FILT_LEN clock cycles are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down_n | input | 1 | Active-low power-down, holds registers at defaults |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| addr_sel | input | 2 | Low two bits of the device address |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| regs_o | output | 56 | Register contents, register k at bits 8k+7:8k |
| defaults_o | output | 56 | Reset values, same layout as regs_o |

## Verification
The transactions cover a matching and a foreign device address, a two-byte burst, and a burst that crosses register 6. The crossing burst separates correct wrapping from overflow into unmapped space. Random reads and current-address reads are run back to back, so a pointer that fails to advance after a sent byte returns the wrong register. An aborted byte, a short glitch on SDA while SCL is high, a pointer outside the map, and writes under power-down are each tried. These cases show the difference between storing data and ignoring it, which a plain write-then-read sequence cannot. A monitor watches that the slave's pull never changes while SCL is high.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

  localparam int REG_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } bus_state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_DATA
  } phase_t;

  // reset value of register idx
  function automatic logic [REG_W-1:0] reg_default(input int idx);
    case (idx)
      0:       return 8'h80;
      1:       return 8'h20;
      2:       return 8'h00;
      default: return 8'h10;
    endcase
  endfunction

endpackage

// File: rtl/i2cr_line_filter.sv
module i2cr_line_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic             s1_q, s2_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      line_o <= 1'b1;
      cnt_q  <= '0;
    end else begin
      s1_q <= line_i;
      s2_q <= s1_q;
      if (s2_q == line_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
        line_o <= s2_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R12: the filtered level only moves towards a level that has been held
  a_r12_filter_follows: assert property (@(posedge clk) disable iff (rst)
    !$stable(line_o) |-> (line_o == $past(s2_q)));

endmodule

// File: rtl/i2cr_regbank.sv
module i2cr_regbank
  import i2cr_pkg::*;
#(
  parameter int NREGS = 7,
  parameter int PTR_W = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pwr_down_n,
  input  logic                   wr_en,
  input  logic [PTR_W-1:0]       wr_addr,
  input  logic [REG_W-1:0]       wr_data,
  input  logic [PTR_W-1:0]       rd_addr,
  output logic [REG_W-1:0]       rd_data,
  output logic [NREGS*REG_W-1:0] regs_o,
  output logic [NREGS*REG_W-1:0] defaults_o
);
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NREGS - 1);

  logic [REG_W-1:0] rd_arr [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    localparam logic [REG_W-1:0] DFLT = reg_default(g);
    logic [REG_W-1:0] r_q;

    always_ff @(posedge clk) begin
      if (rst || !pwr_down_n) begin
        r_q <= DFLT;
      end else if (wr_en && wr_addr == PTR_W'(g)) begin
        r_q <= wr_data;
      end
    end

    assign rd_arr[g]                  = r_q;
    assign regs_o[g*REG_W +: REG_W]     = r_q;
    assign defaults_o[g*REG_W +: REG_W] = DFLT;

    // R8: power-down leaves every register at its reset value
    a_r8_pd_default: assert property (@(posedge clk) disable iff (rst)
      !pwr_down_n |=> (r_q == DFLT));
  end

  always_comb begin
    if (rd_addr <= LAST) rd_data = rd_arr[rd_addr[IDX_W-1:0]];
    else                 rd_data = '0;
  end

  // R11: no write strobe ever targets an unmapped pointer
  a_r11_wr_in_map: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr <= LAST));

endmodule

// File: rtl/i2cr_bus_ctrl.sv
module i2cr_bus_ctrl
  import i2cr_pkg::*;
#(
  parameter int NREGS = 7,
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_f,
  input  logic             sda_f,
  input  logic [6:0]       dev_addr,
  input  logic [REG_W-1:0] rd_data,
  output logic [PTR_W-1:0] rd_addr,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [REG_W-1:0] wr_data,
  output logic             sda_pull
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NREGS - 1);

  bus_state_t       state_q;
  phase_t           phase_q;
  logic             scl_q, sda_q, rw_q, mack_q;
  logic [3:0]       bitcnt_q;
  logic [REG_W-1:0] shreg_q, tx_q;
  logic [PTR_W-1:0] ptr_q;

  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;
  wire bus_start = scl_f & scl_q & sda_q & ~sda_f;
  wire bus_stop  = scl_f & scl_q & ~sda_q & sda_f;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p >= LAST) ? '0 : p + 1'b1;
  endfunction

  assign rd_addr = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_ADDR;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      tx_q     <= '0;
      ptr_q    <= '0;
      sda_pull <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      wr_en <= 1'b0;
      if (bus_start) begin
        state_q  <= ST_RX;
        phase_q  <= PH_ADDR;
        bitcnt_q <= '0;
        sda_pull <= 1'b0;
      end else if (bus_stop) begin
        state_q  <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (state_q)
          ST_RX: begin
            if (scl_rise) begin
              shreg_q  <= {shreg_q[REG_W-2:0], sda_f};
              bitcnt_q <= bitcnt_q + 1'b1;
            end else if (scl_fall && bitcnt_q == 4'd8) begin
              case (phase_q)
                PH_ADDR: begin
                  if (shreg_q[7:1] == dev_addr) begin
                    rw_q     <= shreg_q[0];
                    sda_pull <= 1'b1;
                    state_q  <= ST_ACK;
                  end else begin
                    state_q <= ST_IDLE;
                  end
                end
                PH_PTR: begin
                  ptr_q    <= shreg_q[PTR_W-1:0];
                  sda_pull <= 1'b1;
                  state_q  <= ST_ACK;
                end
                default: begin
                  wr_en    <= (ptr_q <= LAST);
                  wr_addr  <= ptr_q;
                  wr_data  <= shreg_q;
                  ptr_q    <= ptr_next(ptr_q);
                  sda_pull <= 1'b1;
                  state_q  <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (phase_q == PH_ADDR && rw_q) begin
                tx_q     <= rd_data;
                sda_pull <= ~rd_data[7];
                ptr_q    <= ptr_next(ptr_q);
                bitcnt_q <= 4'd1;
                state_q  <= ST_TX;
              end else begin
                sda_pull <= 1'b0;
                bitcnt_q <= '0;
                phase_q  <= (phase_q == PH_ADDR) ? PH_PTR : PH_DATA;
                state_q  <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt_q == 4'd8) begin
                sda_pull <= 1'b0;
                state_q  <= ST_MACK;
              end else begin
                sda_pull <= ~tx_q[6];
                tx_q     <= {tx_q[REG_W-2:0], 1'b0};
                bitcnt_q <= bitcnt_q + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_f;
            end else if (scl_fall) begin
              if (mack_q) begin
                tx_q     <= rd_data;
                sda_pull <= ~rd_data[7];
                ptr_q    <= ptr_next(ptr_q);
                bitcnt_q <= 4'd1;
                state_q  <= ST_TX;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10: SDA is pulled only in an acknowledge slot or a read data bit
  a_r10_pull_in_slot: assert property (@(posedge clk) disable iff (rst)
    sda_pull |-> (state_q == ST_ACK || state_q == ST_TX));

  // R10: the driven level holds while SCL stays high
  a_r10_stable_scl_high: assert property (@(posedge clk) disable iff (rst)
    (scl_f && scl_q) |=> $stable(sda_pull));

  // R3: a data byte stored at the last register sends the pointer to zero
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == LAST) |-> (ptr_q == '0));

  // R1: an acknowledge of the address byte follows a match only
  a_r1_ack_match: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_pull) && state_q == ST_ACK && phase_q == PH_ADDR)
      |-> (shreg_q[7:1] == dev_addr));

endmodule

// File: rtl/i2cr_top.sv
module i2cr_top
  import i2cr_pkg::*;
#(
  parameter int         NREGS      = 7,
  parameter int         PTR_W      = 5,
  parameter int         FILT_LEN   = 4,
  parameter logic [4:0] DEV_PREFIX = 5'b00100
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pwr_down_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  input  logic [1:0]             addr_sel,
  output logic                   sda_pull_o,
  output logic [NREGS*REG_W-1:0] regs_o,
  output logic [NREGS*REG_W-1:0] defaults_o
);
  logic [1:0] raw_lines, clean_lines;
  logic             wr_en;
  logic [PTR_W-1:0] wr_addr, rd_addr;
  logic [REG_W-1:0] wr_data, rd_data;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2cr_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst    (rst),
      .line_i (raw_lines[g]),
      .line_o (clean_lines[g])
    );
  end

  i2cr_bus_ctrl #(.NREGS(NREGS), .PTR_W(PTR_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .scl_f    (clean_lines[0]),
    .sda_f    (clean_lines[1]),
    .dev_addr ({DEV_PREFIX, addr_sel}),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sda_pull (sda_pull_o)
  );

  i2cr_regbank #(.NREGS(NREGS), .PTR_W(PTR_W)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .pwr_down_n (pwr_down_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .regs_o     (regs_o),
    .defaults_o (defaults_o)
  );

endmodule

// File: tb/i2cr_top_bench.sv
`timescale 1ns/1ps
module i2cr_top_bench;
  localparam int Q = 40;
  localparam logic [7:0] AW = 8'h24;  // 00100,1,0, write
  localparam logic [7:0] AR = 8'h25;  // read

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_down_n = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m_low = 1'b0;
  logic [1:0] addr_sel = 2'b10;
  logic sda_pull;
  logic [55:0] regs, dflts;
  wire  sda_line = ~(sda_m_low | sda_pull);

  int checks = 0;
  int fails = 0;
  int hi_changes = 0;
  int pull_seen = 0;
  logic [7:0] expr [7];

  always #2.5 clk = ~clk;

  i2cr_top u_i2cr_top (
    .clk (clk), .rst (rst), .pwr_down_n (pwr_down_n),
    .scl_i (scl_m), .sda_i (sda_line), .addr_sel (addr_sel),
    .sda_pull_o (sda_pull), .regs_o (regs), .defaults_o (dflts)
  );

  // R10 monitor: slave pull must not move while SCL is high
  logic prev_scl = 1'b1, prev_pull = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (scl_m && prev_scl && sda_pull != prev_pull) hi_changes++;
      if (sda_pull) pull_seen++;
    end
    prev_scl  <= scl_m;
    prev_pull <= sda_pull;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m_low = 1'b0; waitq(Q);
    scl_m = 1'b1;     waitq(Q);
    sda_m_low = 1'b1; waitq(Q);
    scl_m = 1'b0;     waitq(Q);
  endtask

  task automatic bus_stop();
    sda_m_low = 1'b1; waitq(Q);
    scl_m = 1'b1;     waitq(Q);
    sda_m_low = 1'b0; waitq(2*Q);
  endtask

  task automatic put_bit(input logic b, input logic glitch);
    sda_m_low = ~b; waitq(Q);
    scl_m = 1'b1;
    if (glitch && b) begin
      waitq(Q/2); sda_m_low = 1'b1; waitq(2); sda_m_low = 1'b0; waitq(2*Q - Q/2 - 2);
    end else begin
      waitq(2*Q);
    end
    scl_m = 1'b0; waitq(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m_low = 1'b0; waitq(Q);
    scl_m = 1'b1;     waitq(Q);
    b = sda_line;     waitq(Q);
    scl_m = 1'b0;     waitq(Q);
  endtask

  task automatic wr_byte(input logic [7:0] d, input logic glitch, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i], glitch);
    get_bit(a);
    acked = ~a;
  endtask

  task automatic rd_byte(input logic master_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(~master_ack, 1'b0);
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < 7; i++) check(tag, regs[i*8 +: 8], expr[i]);
  endtask

  // write burst: pointer then data; updates the model with wrap
  task automatic burst_write(input string tag, input logic [4:0] p, input logic [7:0] d [], input logic update);
    logic a;
    logic [4:0] q;
    bus_start();
    wr_byte(AW, 1'b0, a); check({tag, " addr ack"}, a, 1);
    wr_byte({3'b000, p}, 1'b0, a); check({tag, " ptr ack"}, a, 1);
    q = p;
    foreach (d[i]) begin
      wr_byte(d[i], 1'b0, a); check({tag, " data ack"}, a, 1);
      if (update && q <= 6) expr[q] = d[i];
      q = (q >= 6) ? 5'd0 : q + 5'd1;
    end
    bus_stop();
  endtask

  task automatic t_reset();
    waitq(4);
    for (int i = 0; i < 7; i++) begin
      check("R7 reset value", regs[i*8 +: 8], expr[i]);
      check("R7 defaults_o", dflts[i*8 +: 8], expr[i]);
    end
    check("R10 idle release", sda_pull, 0);
  endtask

  task automatic t_addr();
    logic a;
    bus_start(); wr_byte(AW, 1'b0, a); bus_stop();
    check("R1 matching address acked", a, 1);
    bus_start(); wr_byte(8'h26, 1'b0, a);
    check("R1 foreign address not acked", a, 0);
    wr_byte(8'h00, 1'b0, a);
    check("R1 foreign transaction silent", a, 0);
    bus_stop();
  endtask

  task automatic t_burst();
    burst_write("R2 burst", 5'd3, '{8'h55, 8'h66}, 1'b1);
    check_regs("R2 burst regs");
  endtask

  task automatic t_wrap();
    burst_write("R3 wrap", 5'd5, '{8'hA1, 8'hA2, 8'hA3}, 1'b1);
    check_regs("R3 wrap regs");
  endtask

  task automatic t_random_read();
    logic a;
    logic [7:0] d;
    bus_start();
    wr_byte(AW, 1'b0, a);
    wr_byte(8'h03, 1'b0, a);
    bus_start();  // R9 repeated start begins an address phase
    wr_byte(AR, 1'b0, a); check("R9 repeated start addr ack", a, 1);
    rd_byte(1'b1, d); check("R5 random read first", d, 8'h55);
    rd_byte(1'b0, d); check("R6 continued read", d, 8'h66);
    waitq(Q);
    check("R6 released after master nack", sda_pull, 0);
    bus_stop();
  endtask

  task automatic t_current_read();
    logic a;
    logic [7:0] d;
    bus_start(); wr_byte(AR, 1'b0, a); rd_byte(1'b0, d); bus_stop();
    check("R4 current read reg5", d, 8'hA1);
    bus_start(); wr_byte(AR, 1'b0, a); rd_byte(1'b0, d); bus_stop();
    check("R4 current read reg6", d, 8'hA2);
    bus_start(); wr_byte(AR, 1'b0, a); rd_byte(1'b0, d); bus_stop();
    check("R3 read pointer wraps to reg0", d, 8'hA3);
  endtask

  task automatic t_out_of_range();
    logic a;
    logic [7:0] d;
    burst_write("R11 unmapped write", 5'h1F, '{8'h77}, 1'b0);
    check_regs("R11 unmapped write ignored");
    bus_start(); wr_byte(AW, 1'b0, a); wr_byte(8'h12, 1'b0, a);
    bus_start(); wr_byte(AR, 1'b0, a); rd_byte(1'b0, d); bus_stop();
    check("R11 unmapped read zero", d, 8'h00);
  endtask

  task automatic t_abort();
    logic a;
    bus_start(); wr_byte(AW, 1'b0, a); wr_byte(8'h01, 1'b0, a);
    for (int i = 0; i < 4; i++) put_bit(1'b0, 1'b0);
    bus_stop();
    check("R9 aborted byte not stored", regs[15:8], expr[1]);
    burst_write("R9 after abort", 5'd1, '{8'h42}, 1'b1);
    check("R9 write after abort", regs[15:8], 8'h42);
  endtask

  task automatic t_glitch();
    logic a;
    bus_start(); wr_byte(AW, 1'b0, a); wr_byte(8'h02, 1'b0, a);
    wr_byte(8'hFF, 1'b1, a);
    check("R12 glitched byte acked", a, 1);
    bus_stop();
    expr[2] = 8'hFF;
    check("R12 glitch ignored", regs[23:16], 8'hFF);
  endtask

  task automatic t_powerdown();
    pwr_down_n = 1'b0;
    waitq(4);
    for (int i = 0; i < 7; i++) expr[i] = dflts[i*8 +: 8];
    burst_write("R8 pd write", 5'd2, '{8'h3C}, 1'b0);
    check_regs("R8 held at defaults");
    check("R8 reg0 default", regs[7:0], 8'h80);
    pwr_down_n = 1'b1;
    waitq(4);
    check("R8 write ignored after release", regs[23:16], 8'h00);
    burst_write("R8 write after release", 5'd2, '{8'h3C}, 1'b1);
    check("R8 write works after release", regs[23:16], 8'h3C);
  endtask

  task automatic finish_run();
    check("R10 pull stable while SCL high", hi_changes, 0);
    check("R10 pull observed", pull_seen > 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    expr = '{8'h80, 8'h20, 8'h00, 8'h10, 8'h10, 8'h10, 8'h10};
    waitq(5);
    rst = 1'b0;
    t_reset();
    t_addr();
    t_burst();
    t_wrap();
    t_random_read();
    t_current_read();
    t_out_of_range();
    t_abort();
    t_glitch();
    t_powerdown();
    finish_run();
  end

  initial begin
    repeat (180000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule